// File: doc/BRIEF.md
# Two-Level Serial Word Receiver with Pulse-Width Validation

This block takes a return-to-zero serial avionics line that has already been turned into two logic levels: one input is high while the line carries a "one" pulse, the other while it carries a "zero" pulse, and both are low during the null between pulses. Both inputs are sampled on a 1 MHz reference clock, one sample per clock. Every pulse and every null between pulses is measured in samples and compared with a tolerance window. A bit that falls outside the window aborts the word in progress. Each accepted bit is shifted into a 32-bit register.

When the 32nd bit has been taken, the word moves into a hold register and an active-low ready flag goes low. The host reads the held word as two 16-bit halves chosen by a select input. A read strobe with the upper half selected hands the word back and returns the flag high. A configuration input switches every timing window to the slow line rate. A self-test input makes the receiver listen to the local transmitter's output instead of the external line.

Top module: `a429_rx`

## Requirements
- R1: After 32 valid pulses, the first null sample that follows the 32nd pulse loads the word into the hold register and drives `ready_n` low on that same clock edge.
- R2: The first bit received is word bit 0. With `sel_half`=0 the bus shows word bits 15..0, and with `sel_half`=1 it shows bits 31..16. The bus is combinational from the hold register and the select input.
- R3: At the fast rate a pulse of 4, 5 or 6 samples is accepted. A pulse of 3 samples or fewer, or of 7 or more, discards the word. A null between pulses must likewise last 4 to 6 samples.
- R4: With `cfg_slow`=1 every window is scaled by 8. Pulses of 38 to 42 samples are accepted, and pulses of 37 or 43 samples discard the word.
- R5: A word is only accepted after at least 4 bit times of continuous null (40 samples fast, 320 slow). A word cut off before its 32nd bit by a null longer than the window is discarded.
- R6: A sample with both level inputs high aborts the current word. That word never raises ready.
- R7: A read strobe (`rd_en`=1) with `sel_half`=1 returns `ready_n` high on the next edge. A strobe with `sel_half`=0 leaves `ready_n` unchanged.
- R8: A new valid word overwrites the held word even if it has not been read. With no new word the held word does not change.
- R9: With `cfg_selftest`=1 the receiver uses `loop_hi`/`loop_lo` and ignores `line_hi`/`line_lo`. With `cfg_selftest`=0 it does the reverse.
- R10: Synchronous active-high reset sets `ready_n` to 1 and clears the hold register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz sampling reference clock |
| rst | input | 1 | Synchronous active-high reset |
| line_hi | input | 1 | External line, "one" level present |
| line_lo | input | 1 | External line, "zero" level present |
| loop_hi | input | 1 | Local transmitter output, "one" level |
| loop_lo | input | 1 | Local transmitter output, "zero" level |
| cfg_selftest | input | 1 | 1 = listen to the loopback inputs |
| cfg_slow | input | 1 | 1 = slow rate, windows scaled by 8 |
| sel_half | input | 1 | Bus half select: 0 = bits 15..0, 1 = bits 31..16 |
| rd_en | input | 1 | Read strobe; with `sel_half`=1 it returns ready high |
| data_bus | output | 16 | Selected half of the held word |
| ready_n | output | 1 | Active-low word-ready flag |

## Verification
The inputs change on the falling clock edge. The completed word and the falling `ready_n` are therefore due at the rising edge that samples the first null after the 32nd pulse, and a second-half read clears the flag at the rising edge that samples the strobe. The bench's model moves its expected flag and expected word at exactly those edges. It compares the flag and the bus one time unit after every rising edge. Rejected words must leave both unchanged through the whole comparison stream.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PULSE = 2'd2,
        ST_SPACE = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } line_sample_t;

    function automatic int win_tol(input int nom);
        return (nom / 20 < 1) ? 1 : nom / 20;
    endfunction

    function automatic int win_min(input int nom);
        return nom - win_tol(nom);
    endfunction

    function automatic int win_max(input int nom);
        return nom + win_tol(nom);
    endfunction

endpackage

// File: rtl/a429_rx_src_mux.sv
module a429_rx_src_mux
    import a429_rx_pkg::*;
(
    input  logic         line_hi,
    input  logic         line_lo,
    input  logic         loop_hi,
    input  logic         loop_lo,
    input  logic         cfg_selftest,
    output line_sample_t samp
);
    always_comb begin
        if (cfg_selftest) begin
            samp.hi = loop_hi;
            samp.lo = loop_lo;
        end else begin
            samp.hi = line_hi;
            samp.lo = line_lo;
        end
    end
endmodule

// File: rtl/a429_rx_framer.sv
module a429_rx_framer
    import a429_rx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int PULSE_NOM = 5,
    parameter int SLOW_MUL  = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  line_sample_t      samp,
    input  logic              cfg_slow,
    output logic              word_done,
    output logic [WORD_W-1:0] word_val
);
    localparam int NOM_F = PULSE_NOM;
    localparam int NOM_S = PULSE_NOM * SLOW_MUL;
    localparam int GAP_F = GAP_BITS * 2 * NOM_F;
    localparam int GAP_S = GAP_BITS * 2 * NOM_S;
    localparam int CNT_W = $clog2(GAP_S + 1);
    localparam int BIT_W = $clog2(WORD_W);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BIT_W-1:0]  nbit_q, nbit_d;
    logic              lvl_q, lvl_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]  lim_min, lim_max, lim_gap;
    logic              is_null, is_bad;

    assign lim_min = cfg_slow ? CNT_W'(win_min(NOM_S)) : CNT_W'(win_min(NOM_F));
    assign lim_max = cfg_slow ? CNT_W'(win_max(NOM_S)) : CNT_W'(win_max(NOM_F));
    assign lim_gap = cfg_slow ? CNT_W'(GAP_S) : CNT_W'(GAP_F);
    assign is_null = !samp.hi && !samp.lo;
    assign is_bad  = samp.hi && samp.lo;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        nbit_d    = nbit_q;
        lvl_d     = lvl_q;
        sh_d      = sh_q;
        word_done = 1'b0;
        word_val  = {lvl_q, sh_q[WORD_W-1:1]};
        if (is_bad) begin
            state_d = ST_SYNC;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_SYNC: begin
                    if (is_null) begin
                        if (cnt_q + 1'b1 >= lim_gap) state_d = ST_ARMED;
                        else cnt_d = cnt_q + 1'b1;
                    end else begin
                        cnt_d = '0;
                    end
                end
                ST_ARMED: begin
                    if (!is_null) begin
                        state_d = ST_PULSE;
                        cnt_d   = CNT_W'(1);
                        lvl_d   = samp.hi;
                        nbit_d  = '0;
                    end
                end
                ST_PULSE: begin
                    if (is_null) begin
                        if (cnt_q < lim_min) begin
                            state_d = ST_SYNC;
                            cnt_d   = '0;
                        end else begin
                            sh_d = {lvl_q, sh_q[WORD_W-1:1]};
                            if (nbit_q == BIT_W'(WORD_W - 1)) begin
                                word_done = 1'b1;
                                state_d   = ST_SYNC;
                                cnt_d     = CNT_W'(1);
                            end else begin
                                state_d = ST_SPACE;
                                cnt_d   = CNT_W'(1);
                                nbit_d  = nbit_q + 1'b1;
                            end
                        end
                    end else if (samp.hi != lvl_q || cnt_q == lim_max) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SPACE: begin
                    if (is_null) begin
                        if (cnt_q == lim_max) begin
                            state_d = ST_SYNC;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else if (cnt_q < lim_min) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_PULSE;
                        cnt_d   = CNT_W'(1);
                        lvl_d   = samp.hi;
                    end
                end
                default: begin
                    state_d = ST_SYNC;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SYNC;
            cnt_q   <= '0;
            nbit_q  <= '0;
            lvl_q   <= 1'b0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            nbit_q  <= nbit_d;
            lvl_q   <= lvl_d;
            sh_q    <= sh_d;
        end
    end
endmodule

// File: rtl/a429_rx_hold.sv
module a429_rx_hold #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_val,
    input  logic              rd_en,
    input  logic              sel_half,
    output logic [WORD_W-1:0] hold_q,
    output logic              ready_n,
    output logic [WORD_W/2-1:0] data_bus
);
    localparam int HALF_W = WORD_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_n <= 1'b1;
        end else if (word_done) begin
            hold_q  <= word_val;
            ready_n <= 1'b0;
        end else if (rd_en && sel_half) begin
            ready_n <= 1'b1;
        end
    end

    assign data_bus = sel_half ? hold_q[WORD_W-1:HALF_W] : hold_q[HALF_W-1:0];
endmodule

// File: rtl/a429_rx.sv
module a429_rx
    import a429_rx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int PULSE_NOM = 5,
    parameter int SLOW_MUL  = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_hi,
    input  logic              line_lo,
    input  logic              loop_hi,
    input  logic              loop_lo,
    input  logic              cfg_selftest,
    input  logic              cfg_slow,
    input  logic              sel_half,
    input  logic              rd_en,
    output logic [WORD_W/2-1:0] data_bus,
    output logic              ready_n
);
    line_sample_t      samp;
    logic              word_done;
    logic [WORD_W-1:0] word_val;
    logic [WORD_W-1:0] hold_q;

    a429_rx_src_mux u_src (
        .line_hi(line_hi), .line_lo(line_lo),
        .loop_hi(loop_hi), .loop_lo(loop_lo),
        .cfg_selftest(cfg_selftest), .samp(samp)
    );

    a429_rx_framer #(
        .WORD_W(WORD_W), .PULSE_NOM(PULSE_NOM),
        .SLOW_MUL(SLOW_MUL), .GAP_BITS(GAP_BITS)
    ) u_framer (
        .clk(clk), .rst(rst), .samp(samp), .cfg_slow(cfg_slow),
        .word_done(word_done), .word_val(word_val)
    );

    a429_rx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst(rst), .word_done(word_done), .word_val(word_val),
        .rd_en(rd_en), .sel_half(sel_half), .hold_q(hold_q),
        .ready_n(ready_n), .data_bus(data_bus)
    );
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        samp,
    input logic              word_done,
    input logic              rd_en,
    input logic              sel_half,
    input logic              ready_n,
    input logic [WORD_W-1:0] hold_q
);
    p_done_sets_ready_r1: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !ready_n);

    p_upper_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel_half && !word_done) |=> ready_n);

    p_ready_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (!word_done && !(rd_en && sel_half)) |=> $stable(ready_n));

    p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
        !word_done |=> $stable(hold_q));

    p_both_high_aborts_r6: assert property (@(posedge clk) disable iff (rst)
        (samp == 2'b11) |=> !word_done);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (ready_n && hold_q == '0));
endmodule

bind a429_rx a429_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .samp(samp), .word_done(word_done),
    .rd_en(rd_en), .sel_half(sel_half), .ready_n(ready_n), .hold_q(hold_q)
);

// File: tb/a429_rx_bench.sv
module a429_rx_bench;
    localparam int CLK_NS = 1000;
    localparam int GAP_F  = 45;
    localparam int GAP_S  = 330;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_hi = 1'b0, line_lo = 1'b0, loop_hi = 1'b1, loop_lo = 1'b1;
    logic cfg_selftest = 1'b0, cfg_slow = 1'b0, sel_half = 1'b0, rd_en = 1'b0;
    logic [15:0] data_bus;
    logic ready_n;

    int errors = 0;
    int checks = 0;
    bit use_loop = 1'b0;
    bit mon_on = 1'b0;
    string cur_tag = "R10";

    logic        exp_ready = 1'b1;
    logic [31:0] exp_hold  = 32'h0;
    bit          pend_done = 1'b0;
    logic [31:0] pend_w    = 32'h0;
    bit          pend_clear = 1'b0;

    a429_rx u_a429_rx (
        .clk(clk), .rst(rst), .line_hi(line_hi), .line_lo(line_lo),
        .loop_hi(loop_hi), .loop_lo(loop_lo), .cfg_selftest(cfg_selftest),
        .cfg_slow(cfg_slow), .sel_half(sel_half), .rd_en(rd_en),
        .data_bus(data_bus), .ready_n(ready_n)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: applies expected changes at the edge they are due, then compares.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (pend_done) begin
                exp_ready = 1'b0;
                exp_hold  = pend_w;
                pend_done = 1'b0;
            end else if (pend_clear) begin
                exp_ready = 1'b1;
            end
            pend_clear = 1'b0;
            check_eq({cur_tag, " ready_n per clock"}, {31'b0, ready_n}, {31'b0, exp_ready});
            check_eq({cur_tag, " bus per clock"}, {16'b0, data_bus},
                     {16'b0, sel_half ? exp_hold[31:16] : exp_hold[15:0]});
        end
    end

    task automatic drive(input logic [1:0] v);
        if (use_loop) begin
            {loop_hi, loop_lo} = v;
            {line_hi, line_lo} = 2'b11;
        end else begin
            {line_hi, line_lo} = v;
            {loop_hi, loop_lo} = 2'b11;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drive(2'b00);
        end
    endtask

    // Sends nb bits of w; bit number bad gets both levels high; ok says if it must land.
    task automatic send_word(input logic [31:0] w, input int pw, input int nw,
                             input int nb, input int bad, input bit ok);
        for (int i = 0; i < nb; i++) begin
            for (int k = 0; k < pw; k++) begin
                @(negedge clk);
                if (i == bad) drive(2'b11);
                else drive(w[i] ? 2'b10 : 2'b01);
            end
            @(negedge clk);
            drive(2'b00);
            if (i == 31 && ok) begin
                pend_w    = w;
                pend_done = 1'b1;
            end
            for (int k = 1; k < nw; k++) begin
                @(negedge clk);
                drive(2'b00);
            end
        end
    endtask

    task automatic do_read(input logic s);
        @(negedge clk);
        sel_half = s;
        rd_en    = 1'b1;
        if (s) pend_clear = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_halves(input string tag, input logic [31:0] w);
        @(negedge clk);
        sel_half = 1'b0;
        #1 check_eq({tag, " low half"}, {16'b0, data_bus}, {16'b0, w[15:0]});
        sel_half = 1'b1;
        #1 check_eq({tag, " high half"}, {16'b0, data_bus}, {16'b0, w[31:16]});
        sel_half = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive(2'b00);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        check_eq("R10 reset ready_n", {31'b0, ready_n}, 32'd1);
        check_eq("R10 reset bus", {16'b0, data_bus}, 32'd0);
        mon_on = 1'b1;
        idle(GAP_F);

        cur_tag = "R1";
        send_word(32'hA5C3_1E87, 5, 5, 32, -1, 1'b1);
        idle(3);
        check_eq("R1 ready after word", {31'b0, ready_n}, 32'd0);
        cur_tag = "R2";
        check_halves("R2", 32'hA5C3_1E87);

        cur_tag = "R7";
        do_read(1'b0);
        idle(2);
        check_eq("R7 low-half read keeps ready", {31'b0, ready_n}, 32'd0);
        do_read(1'b1);
        idle(2);
        check_eq("R7 high-half read clears ready", {31'b0, ready_n}, 32'd1);
        idle(GAP_F);

        cur_tag = "R3";
        send_word(32'h1234_5678, 4, 4, 32, -1, 1'b1);
        idle(GAP_F);
        check_eq("R3 width 4 accepted", exp_hold, 32'h1234_5678);
        do_read(1'b1);
        send_word(32'h0F0F_F0F0, 6, 6, 32, -1, 1'b1);
        idle(GAP_F);
        check_eq("R3 width 6 accepted", {31'b0, ready_n}, 32'd0);
        do_read(1'b1);
        idle(GAP_F);
        send_word(32'hDEAD_BEEF, 3, 5, 32, -1, 1'b0);
        idle(GAP_F);
        check_eq("R3 width 3 rejected", {31'b0, ready_n}, 32'd1);
        send_word(32'hDEAD_BEEF, 7, 5, 32, -1, 1'b0);
        idle(GAP_F);
        check_eq("R3 width 7 rejected", {31'b0, ready_n}, 32'd1);
        send_word(32'hDEAD_BEEF, 5, 3, 32, -1, 1'b0);
        idle(GAP_F);
        check_eq("R3 null 3 rejected", {31'b0, ready_n}, 32'd1);

        cur_tag = "R5";
        send_word(32'h1111_2222, 5, 5, 32, -1, 1'b1);
        idle(20);
        send_word(32'h3333_4444, 5, 5, 32, -1, 1'b0);
        idle(GAP_F);
        check_eq("R5 short gap word ignored", exp_hold, 32'h1111_2222);
        do_read(1'b1);
        send_word(32'h5555_6666, 5, 5, 10, -1, 1'b0);
        idle(GAP_F);
        check_eq("R5 truncated word discarded", {31'b0, ready_n}, 32'd1);

        cur_tag = "R6";
        send_word(32'h7777_8888, 5, 5, 32, 12, 1'b0);
        idle(GAP_F);
        check_eq("R6 both-high word discarded", {31'b0, ready_n}, 32'd1);

        cur_tag = "R8";
        send_word(32'hCAFE_0001, 5, 5, 32, -1, 1'b1);
        idle(GAP_F);
        do_read(1'b0);
        send_word(32'hBEEF_0002, 5, 5, 32, -1, 1'b1);
        idle(3);
        check_eq("R8 unread word overwritten", exp_hold, 32'hBEEF_0002);
        check_halves("R8", 32'hBEEF_0002);
        do_read(1'b1);
        idle(GAP_F);

        cur_tag = "R9";
        cfg_selftest = 1'b1;
        use_loop = 1'b1;
        idle(GAP_F);
        send_word(32'h9ABC_DEF0, 5, 5, 32, -1, 1'b1);
        idle(3);
        check_eq("R9 loopback word received", {31'b0, ready_n}, 32'd0);
        check_halves("R9", 32'h9ABC_DEF0);
        do_read(1'b1);
        cfg_selftest = 1'b0;
        use_loop = 1'b0;
        idle(GAP_F);
        send_word(32'h0000_FFFF, 5, 5, 32, -1, 1'b1);
        idle(3);
        check_eq("R9 line word received", exp_hold, 32'h0000_FFFF);
        do_read(1'b1);

        cur_tag = "R4";
        @(negedge clk);
        cfg_slow = 1'b1;
        idle(GAP_S);
        send_word(32'h8421_1248, 40, 40, 32, -1, 1'b1);
        idle(3);
        check_eq("R4 slow width 40 accepted", {31'b0, ready_n}, 32'd0);
        do_read(1'b1);
        idle(GAP_S);
        send_word(32'h0102_0304, 38, 42, 32, -1, 1'b1);
        idle(GAP_S);
        check_eq("R4 slow width 38 accepted", exp_hold, 32'h0102_0304);
        do_read(1'b1);
        send_word(32'hFFFF_0000, 37, 40, 32, -1, 1'b0);
        idle(GAP_S);
        check_eq("R4 slow width 37 rejected", {31'b0, ready_n}, 32'd1);
        send_word(32'hFFFF_0000, 43, 40, 32, -1, 1'b0);
        idle(GAP_S);
        check_eq("R4 slow width 43 rejected", {31'b0, ready_n}, 32'd1);
        check_halves("R4", 32'h0102_0304);

        mon_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule